// File: doc/BRIEF.md
# Position Capture Trigger Unit

This block serves one encoder channel. It watches the encoder index pulse and one chosen switch flag, and it latches the live encoder count when a programmed trigger condition appears. The flag is picked by type (home, negative limit, positive limit, user) and by source channel, from any of four channels. The index and the flag each have their own enable and their own polarity. The index can also be narrowed to a single quadrature state. This lets motion in either direction capture the same count.

The condition is tested only on cycles where the sample-clock enable is high. The capture fires on a rising edge of the combined condition, so the latched count is exact to the sample. The captured count leaves through a valid/ready output. `capt_valid` is the sticky capture flag. It stays high, with the count frozen, until software reads the count by raising `capt_ready`. That completes the handshake and re-arms the unit. While the output is held (valid high, ready low), back-pressure is absolute: every new trigger is dropped. There is no queue.

Setup is one write strobe that loads all configuration fields at once.

Top module: `capture_trigger_unit`

## Requirements
- R1: After reset, `capt_valid` is 0 and `capt_count` is 0. The configuration is all zero, so no trigger source is enabled.
- R2: Control bit 0 enables the index in the trigger, and bit 2 inverts it. The qualified index is `index_in XOR bit2`.
- R3: Control bit 1 enables the flag in the trigger, and bit 3 inverts it. The qualified flag is the selected flag XOR bit 3.
- R4: Flag type select values pick the flag from within a channel: 0 = home (bit 0 of the channel's nibble), 1 = negative limit (bit 1), 2 = positive limit (bit 2), 3 = user (bit 3).
- R5: Flag channel select c (0..3) takes the flag from `flags_in[4c+3:4c]`.
- R6: With index gating enabled, the qualified index only counts while the quadrature inputs are in one state. That state is A=1 and B=1 when the gate-state bit is 0, and A=0 and B=0 when it is 1. Gating is applied after the inversion.
- R7: With both control bits 0 and 1 set, the condition is the AND of the qualified index and the qualified flag. With exactly one of them set, the condition is that source alone.
- R8: With control bits 0 and 1 both clear, the unit never captures.
- R9: The condition is evaluated only at clock edges where `sample_en` is 1. A capture at such an edge loads `count_in` from that edge. `capt_valid` reads 1 from the following cycle on.
- R10: A capture needs a rising edge of the condition between two consecutive samples. The previous sample is taken as 0 after reset. A condition that stays high captures only once.
- R11: While `capt_valid` is 1 and `capt_ready` is 0, `capt_count` and `capt_valid` hold, and triggers are ignored. The condition history keeps updating on every sample during this time.
- R12: At an edge where `capt_valid` and `capt_ready` are both 1, `capt_valid` clears and the unit re-arms. `capt_count` keeps its last value.
- R13: `cfg_wr` loads all configuration fields at the clock edge. Samples at that same edge still use the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Sample-clock enable; the condition is tested on these cycles |
| count_in | input | CNT_W | Live encoder count |
| enc_a | input | 1 | Filtered quadrature A |
| enc_b | input | 1 | Filtered quadrature B |
| index_in | input | 1 | Encoder index pulse |
| flags_in | input | 16 | Four flags per channel, channel c at [4c+3:4c] |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ctrl | input | 4 | Control word: idx enable, flag enable, idx invert, flag invert |
| cfg_ftype | input | 2 | Flag type select |
| cfg_fchan | input | 2 | Flag channel select |
| cfg_gate_en | input | 1 | Index gating enable |
| cfg_gate_state | input | 1 | Gating state: 0 both high, 1 both low |
| capt_ready | input | 1 | Software read of the captured count |
| capt_valid | output | 1 | Sticky capture flag |
| capt_count | output | CNT_W | Captured count |

## Verification
A trigger seen at a sampling edge shows up as `capt_valid` high and the new `capt_count` exactly one cycle later. A ready handshake clears the flag one cycle after the edge where it is seen. A configuration write changes behaviour only from the next edge. The bench drives inputs and compares outputs at the falling edge. After each rising edge it advances a behavioural model that follows these same one-edge latencies. It then compares both outputs with the model on every cycle, so an early, late or missing capture is caught in the exact cycle where it goes wrong.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int NUM_CH   = 4;
  localparam int NUM_FLG  = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int FT_W     = $clog2(NUM_FLG);
  localparam int FLAGS_W  = NUM_CH * NUM_FLG;

  // control word bit positions
  localparam int CB_IDX_EN  = 0;
  localparam int CB_FLG_EN  = 1;
  localparam int CB_IDX_INV = 2;
  localparam int CB_FLG_INV = 3;

  typedef struct packed {
    logic [3:0]      ctrl;
    logic [FT_W-1:0] ftype;
    logic [CH_W-1:0] fchan;
    logic            gate_en;
    logic            gate_state;
  } cap_cfg_t;
endpackage

// File: rtl/cap_cfg_reg.sv
module cap_cfg_reg
  import cap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  cap_cfg_t d,
  output cap_cfg_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/cap_trig_cond.sv
module cap_trig_cond
  import cap_pkg::*;
(
  input  cap_cfg_t             cfg,
  input  logic                 enc_a,
  input  logic                 enc_b,
  input  logic                 index_in,
  input  logic [FLAGS_W-1:0]   flags_in,
  output logic                 cond
);
  logic [NUM_FLG-1:0] ch_flags [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_split
    assign ch_flags[c] = flags_in[c*NUM_FLG +: NUM_FLG];
  end

  logic sel_flag, q_flag, q_idx, gate_ok;

  always_comb begin
    sel_flag = ch_flags[cfg.fchan][cfg.ftype];
    q_flag   = sel_flag ^ cfg.ctrl[CB_FLG_INV];
    gate_ok  = cfg.gate_state ? (~enc_a & ~enc_b) : (enc_a & enc_b);
    q_idx    = (index_in ^ cfg.ctrl[CB_IDX_INV]) & (~cfg.gate_en | gate_ok);
    unique case ({cfg.ctrl[CB_FLG_EN], cfg.ctrl[CB_IDX_EN]})
      2'b11:   cond = q_idx & q_flag;
      2'b01:   cond = q_idx;
      2'b10:   cond = q_flag;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             cond,
  input  logic [CNT_W-1:0] count_in,
  input  logic             ready,
  output logic             valid,
  output logic [CNT_W-1:0] count_q
);
  logic cond_prev;
  logic fire;

  assign fire = sample_en & cond & ~cond_prev & ~valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_prev <= 1'b0;
      valid     <= 1'b0;
      count_q   <= '0;
    end else begin
      if (sample_en) cond_prev <= cond;
      if (fire) begin
        valid   <= 1'b1;
        count_q <= count_in;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/capture_trigger_unit.sv
module capture_trigger_unit
  import cap_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [CNT_W-1:0]   count_in,
  input  logic               enc_a,
  input  logic               enc_b,
  input  logic               index_in,
  input  logic [15:0]        flags_in,
  input  logic               cfg_wr,
  input  logic [3:0]         cfg_ctrl,
  input  logic [1:0]         cfg_ftype,
  input  logic [1:0]         cfg_fchan,
  input  logic               cfg_gate_en,
  input  logic               cfg_gate_state,
  input  logic               capt_ready,
  output logic               capt_valid,
  output logic [CNT_W-1:0]   capt_count
);
  cap_cfg_t cfg_d, cfg_q;
  logic     trig_cond;

  assign cfg_d = '{ctrl: cfg_ctrl, ftype: cfg_ftype, fchan: cfg_fchan,
                   gate_en: cfg_gate_en, gate_state: cfg_gate_state};

  cap_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .d(cfg_d), .q(cfg_q)
  );

  cap_trig_cond u_cond (
    .cfg(cfg_q), .enc_a(enc_a), .enc_b(enc_b), .index_in(index_in),
    .flags_in(flags_in), .cond(trig_cond)
  );

  cap_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .cond(trig_cond),
    .count_in(count_in), .ready(capt_ready), .valid(capt_valid),
    .count_q(capt_count)
  );
endmodule

// File: rtl/cap_trig_checker.sv
module cap_trig_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic [CNT_W-1:0] count_in,
  input logic             capt_ready,
  input logic             capt_valid,
  input logic [CNT_W-1:0] capt_count,
  input logic [3:0]       ctrl_q
);
  assert_no_capture_off_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> !$rose(capt_valid));

  assert_count_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capt_valid) |-> capt_count == $past(count_in));

  assert_hold_under_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    capt_valid && !capt_ready |=> capt_valid && $stable(capt_count));

  assert_handshake_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    capt_valid && capt_ready |=> !capt_valid);

  assert_disabled_never_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] && !ctrl_q[1] |=> !$rose(capt_valid));
endmodule

bind capture_trigger_unit cap_trig_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .count_in(count_in),
  .capt_ready(capt_ready), .capt_valid(capt_valid), .capt_count(capt_count),
  .ctrl_q(cfg_q.ctrl)
);

// File: tb/capture_trigger_unit_bench.sv
module capture_trigger_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic [CW-1:0] count_in = '0;
  logic enc_a = 1'b0, enc_b = 1'b0, index_in = 1'b0;
  logic [15:0] flags_in = '0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_ctrl = '0;
  logic [1:0] cfg_ftype = '0, cfg_fchan = '0;
  logic cfg_gate_en = 1'b0, cfg_gate_state = 1'b0;
  logic capt_ready = 1'b0;
  logic capt_valid;
  logic [CW-1:0] capt_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_trigger_unit #(.CNT_W(CW)) u_capture_trigger_unit (.*);

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int m_ctrl = 0, m_ft = 0, m_fc = 0, m_ge = 0, m_gs = 0;
  int m_prev = 0, m_valid = 0;
  int m_cnt = 0;

  function automatic int model_cond();
    int idx, flg;
    idx = index_in ^ m_ctrl[2];
    if (m_ge != 0) idx = idx & (m_gs != 0 ? int'(!enc_a && !enc_b) : int'(enc_a && enc_b));
    flg = flags_in[m_fc*4 + m_ft] ^ m_ctrl[3];
    if (m_ctrl[0] && m_ctrl[1]) return idx & flg;
    if (m_ctrl[0]) return idx;
    if (m_ctrl[1]) return flg;
    return 0;
  endfunction

  task automatic compare();
    vectors++;
    if (capt_valid !== m_valid[0] || capt_count !== CW'(m_cnt)) begin
      miscompares++;
      $display("FAIL %s: valid=%0b count=%0d expected valid=%0b count=%0d",
               cur_req, capt_valid, capt_count, m_valid[0], CW'(m_cnt));
    end
  endtask

  task automatic tick();
    int c, old_valid;
    @(posedge clk);
    c = model_cond();
    old_valid = m_valid;
    if (sample_en) begin
      if (c != 0 && m_prev == 0 && old_valid == 0) begin
        m_valid = 1;
        m_cnt = int'(count_in);
      end
      m_prev = c;
    end
    if (old_valid != 0 && capt_ready) m_valid = 0;
    if (cfg_wr) begin
      m_ctrl = int'(cfg_ctrl); m_ft = int'(cfg_ftype); m_fc = int'(cfg_fchan);
      m_ge = int'(cfg_gate_en); m_gs = int'(cfg_gate_state);
    end
    @(negedge clk);
    compare();
    cfg_wr = 1'b0;
    count_in = count_in + CW'(3);
  endtask

  task automatic set_cfg(input logic [3:0] c, input logic [1:0] ft, input logic [1:0] fc,
                         input logic ge, input logic gs);
    cfg_ctrl = c; cfg_ftype = ft; cfg_fchan = fc; cfg_gate_en = ge; cfg_gate_state = gs;
    cfg_wr = 1'b1; sample_en = 1'b0;
    tick();
  endtask

  task automatic drain();
    sample_en = 1'b0; capt_ready = 1'b1; tick(); capt_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    sample_en = 1'b1; index_in = 1'b1; tick(); tick();   // R8: nothing enabled
    index_in = 1'b0; tick();

    // R13 + R2: enable index only; write edge itself uses old cfg
    cur_req = "R13";
    index_in = 1'b1; set_cfg(4'b0001, 2'd0, 2'd0, 1'b0, 1'b0);
    cur_req = "R2";
    sample_en = 1'b1; tick(); tick();                    // rising seen (prev 0) -> capture
    cur_req = "R11";
    index_in = 1'b0; tick(); index_in = 1'b1; tick(); tick();
    cur_req = "R12";
    drain();
    cur_req = "R10";
    sample_en = 1'b1; tick(); tick();                    // held high: no recapture
    index_in = 1'b0; tick(); index_in = 1'b1; tick(); tick();
    drain();

    // R9: edge without sample enable
    cur_req = "R9";
    sample_en = 1'b1; index_in = 1'b0; tick();
    sample_en = 1'b0; index_in = 1'b1; tick(); tick();
    sample_en = 1'b1; tick(); tick();
    drain();

    // R2 inverted index
    cur_req = "R2";
    index_in = 1'b1; set_cfg(4'b0101, 2'd0, 2'd0, 1'b0, 1'b0);
    sample_en = 1'b1; tick(); index_in = 1'b0; tick(); tick();
    drain();

    // R4/R5: every type and channel
    for (int ch = 0; ch < 4; ch++) begin
      for (int ft = 0; ft < 4; ft++) begin
        cur_req = (ft == ch) ? "R4" : "R5";
        flags_in = '0; index_in = 1'b0;
        set_cfg(4'b0010, 2'(ft), 2'(ch), 1'b0, 1'b0);
        sample_en = 1'b1; tick();
        flags_in = ~(16'h1 << (ch*4 + ft)); tick();      // wrong bits only
        flags_in = 16'h1 << (ch*4 + ft); tick(); tick();
        drain();
      end
    end

    // R3 inverted flag
    cur_req = "R3";
    flags_in = 16'hFFFF; set_cfg(4'b1010, 2'd2, 2'd1, 1'b0, 1'b0);
    sample_en = 1'b1; tick(); flags_in = 16'hFFFF & ~16'h0040; tick(); tick();
    drain();

    // R6 gating, both states
    for (int gs = 0; gs < 2; gs++) begin
      cur_req = "R6";
      index_in = 1'b0; set_cfg(4'b0001, 2'd0, 2'd0, 1'b1, 1'(gs));
      sample_en = 1'b1;
      enc_a = 1'(gs); enc_b = 1'(gs); index_in = 1'b1; tick();     // wrong state
      enc_a = 1'b1; enc_b = 1'b0; tick();
      enc_a = 1'(~gs); enc_b = 1'(~gs); tick(); tick();             // right state
      drain();
      index_in = 1'b0; tick();
    end

    // R7 AND of index and flag
    cur_req = "R7";
    flags_in = '0; index_in = 1'b0; set_cfg(4'b0011, 2'd3, 2'd3, 1'b0, 1'b0);
    sample_en = 1'b1; index_in = 1'b1; tick(); tick();
    index_in = 1'b0; flags_in = 16'h8000; tick();
    index_in = 1'b1; tick(); tick();
    drain();

    // R8 nothing enabled
    cur_req = "R8";
    set_cfg(4'b1100, 2'd0, 2'd0, 1'b0, 1'b0);
    sample_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      index_in = 1'(i[0]); flags_in = 16'(i * 4099); enc_a = i[1]; enc_b = i[2]; tick();
    end

    // mixed traffic
    cur_req = "R7";
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) begin
        set_cfg(4'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      end
      sample_en = 1'($urandom); index_in = 1'($urandom); enc_a = 1'($urandom);
      enc_b = 1'($urandom); flags_in = 16'($urandom); capt_ready = ($urandom % 4) == 0;
      tick();
    end
    capt_ready = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule